// File: doc/BRIEF.md
# Dual-Protocol Parallel Host Bus Slave

This block is the register-access front end of a data acquisition device. It sits on an eight-bit host bus with a three-bit address. A pair of static strap inputs tells it which of two bus conventions to follow. In the first, the host has separate read and write strobes, and the device drives a wait line low while the access is in progress. In the second, the host has one data strobe plus a read/not-write level, and the device drives an acknowledge low once the data is valid.

An access begins when the active strobe and both active-low chip selects are low together. It ends when any of them goes high again. All bus control inputs are resynchronised to the internal clock before they are interpreted. The access is then carried out exactly once.

Only eight bus addresses exist. Address 0 holds a pointer into a wider internal register space. Address 1 is a data window onto that space, and each access through it advances the pointer by one. Addresses 2 and up are local control registers that the rest of the device reads directly. An enable output for external data buffers is driven low only while a selected read is in progress.

Top module: `hbus_slave`

## Requirements
- R1: While `rst` is high and after its release, the pointer, every local control register and `dout` are zero, `ack_n` and `dbuf_en_n` are high, and neither `ext_wr` nor `ext_rd` pulses.
- R2: No access takes place unless the strobe and both chip selects are low together. With either chip select high, `ack_n` stays high, no internal strobe pulses and no register changes.
- R3: When `mode_sel` is any value other than 2'b01, the separate-strobe protocol is used. `rd_n` low requests a read and `wr_n` low requests a write. `ack_n` goes low on the (SYNC_STAGES+1)-th rising edge after the strobe falls. It stays low for exactly WAIT_CYC clocks, and then rises with the read data already on `dout`.
- R4: When `mode_sel` is 2'b01, `rd_n` is the data strobe and `wr_n` is the direction level (1 = read, 0 = write). `ack_n` goes low one clock after the data is ready, that is on the (SYNC_STAGES+2)-th edge after the strobe falls. It stays low for as long as the strobe is held, and rises on the (SYNC_STAGES+1)-th edge after the strobe rises.
- R5: Bus address 0 reads and writes the pointer. Writes take the low PTR_W bits of `din`, and reads return the pointer zero-extended.
- R6: At bus address 1, a read pulses `ext_rd` for one clock with `ext_addr` equal to the pointer, and returns `ext_rdata` from that clock. A write pulses `ext_wr` for one clock with `ext_wdata` = `din`. After either, the pointer advances by one, wrapping from its maximum to zero.
- R7: Bus address k (k >= 2) is a local register that reads back what was written. It appears on `dir_regs[(k-2)*DATA_W +: DATA_W]`.
- R8: `dbuf_en_n` is low only between the start and the end of a selected read. It stays high for writes and while idle.
- R9: Each access performs exactly one register operation, however long the strobe is held. A further operation needs the strobe or a chip select to return high first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | internal clock |
| rst | input | 1 | synchronous reset, active high |
| mode_sel | input | 2 | static protocol strap, 2'b01 = data-strobe protocol |
| cs_a_n | input | 1 | first chip select, active low |
| cs_b_n | input | 1 | second chip select, active low |
| rd_n | input | 1 | read strobe, or data strobe in data-strobe protocol |
| wr_n | input | 1 | write strobe, or read/not-write level |
| addr | input | ADDR_W | bus register address |
| din | input | DATA_W | write data from host |
| dout | output | DATA_W | read data to host |
| dbuf_en_n | output | 1 | external data buffer enable, active low |
| ack_n | output | 1 | wait (separate-strobe) or acknowledge (data-strobe) line |
| ext_wr | output | 1 | indirect register write pulse |
| ext_rd | output | 1 | indirect register read pulse |
| ext_addr | output | PTR_W | indirect register address (pointer) |
| ext_wdata | output | DATA_W | indirect register write data |
| ext_rdata | input | DATA_W | indirect register read data |
| dir_regs | output | (2**ADDR_W-2)*DATA_W | local control registers, packed |

## Verification
The bench builds the block with PTR_W = 4 and WAIT_CYC = 4, and keeps two synchroniser stages and a three-bit address. The four-bit pointer lets a pointer wrap be reached with one write to the maximum value. A four-clock wait window can be told apart from the one-clock sequencing that the data-strobe protocol uses. With six local registers, every slice of `dir_regs` can be written and read back in either protocol. Latencies are measured in whole clocks from the moment a pin changes, and checked against the synchroniser depth.

// File: rtl/hbus_pkg.sv
package hbus_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_BUSY = 2'd1,
      ST_HOLD = 2'd2
   } acc_state_t;

   typedef enum logic {
      PROTO_STROBES = 1'b0,
      PROTO_DSTROBE = 1'b1
   } proto_t;

   localparam logic [1:0] MODE_DSTROBE = 2'b01;
endpackage

// File: rtl/hbus_sync.sv
module hbus_sync #(
   parameter int WIDTH  = 4,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   if (STAGES < 2 || STAGES > 4) begin : g_bad_stages
      $error("hbus_sync: STAGES must lie in 2..4");
   end

   logic [WIDTH-1:0] chain [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk) begin
            if (rst) chain[0] <= '1;
            else     chain[0] <= d;
         end
      end else begin : g_next
         always_ff @(posedge clk) begin
            if (rst) chain[s] <= '1;
            else     chain[s] <= chain[s-1];
         end
      end
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/hbus_ctrl.sv
module hbus_ctrl
   import hbus_pkg::*;
#(
   parameter int WAIT_CYC = 3
) (
   input  logic   clk,
   input  logic   rst,
   input  proto_t proto,
   input  logic   cs_a_s,
   input  logic   cs_b_s,
   input  logic   rd_s,
   input  logic   wr_s,
   output logic   start,
   output logic   exec,
   output logic   is_read,
   output logic   dbuf_en_n,
   output logic   ack_n
);
   if (WAIT_CYC < 1 || WAIT_CYC > 6) begin : g_bad_wait
      $error("hbus_ctrl: WAIT_CYC must lie in 1..6");
   end

   localparam int CNT_W = (WAIT_CYC > 1) ? $clog2(WAIT_CYC) : 1;
   localparam logic [CNT_W-1:0] WAIT_LOAD = CNT_W'(WAIT_CYC - 1);

   acc_state_t       state;
   proto_t           proto_q;
   logic [CNT_W-1:0] cnt;
   logic             sel;
   logic             rd_now;
   logic             cs_ok;

   // selected condition and requested direction for the strapped protocol
   always_comb begin
      cs_ok = !cs_a_s && !cs_b_s;
      if (proto == PROTO_DSTROBE) begin
         sel    = cs_ok && !rd_s;
         rd_now = wr_s;
      end else begin
         sel    = cs_ok && (!rd_s || !wr_s);
         rd_now = !rd_s;
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         state   <= ST_IDLE;
         proto_q <= PROTO_STROBES;
         cnt     <= '0;
         is_read <= 1'b0;
      end else begin
         case (state)
            ST_IDLE: if (sel) begin
               state   <= ST_BUSY;
               proto_q <= proto;
               is_read <= rd_now;
               cnt     <= (proto == PROTO_DSTROBE) ? '0 : WAIT_LOAD;
            end
            ST_BUSY: begin
               if (cnt == '0) state <= ST_HOLD;
               else           cnt   <= cnt - 1'b1;
            end
            ST_HOLD: if (!sel) state <= ST_IDLE;
            default: state <= ST_IDLE;
         endcase
      end
   end

   assign start     = (state == ST_IDLE) && sel;
   assign exec      = (state == ST_BUSY) && (cnt == '0);
   assign dbuf_en_n = !((state != ST_IDLE) && is_read);

   always_comb begin
      if (proto_q == PROTO_STROBES) ack_n = (state != ST_BUSY);
      else                          ack_n = (state != ST_HOLD);
   end

   AST_EXEC_SINGLE: assert property (@(posedge clk) disable iff (rst)
      exec |=> !exec);                                                       // R9
   AST_WAIT_AFTER_SEL: assert property (@(posedge clk) disable iff (rst)
      (proto_q == PROTO_STROBES && $fell(ack_n)) |-> $past(sel));            // R3
   AST_ACK_AFTER_DATA: assert property (@(posedge clk) disable iff (rst)
      (proto_q == PROTO_DSTROBE && $fell(ack_n)) |-> $past(exec));           // R4
   AST_ACK_HELD: assert property (@(posedge clk) disable iff (rst)
      (proto_q == PROTO_DSTROBE && !ack_n && sel) |=> !ack_n);               // R4
endmodule

// File: rtl/hbus_regs.sv
module hbus_regs #(
   parameter int ADDR_W = 3,
   parameter int DATA_W = 8,
   parameter int PTR_W  = 8
) (
   input  logic                              clk,
   input  logic                              rst,
   input  logic                              start,
   input  logic                              exec,
   input  logic                              is_read,
   input  logic [ADDR_W-1:0]                 addr,
   input  logic [DATA_W-1:0]                 din,
   output logic [DATA_W-1:0]                 dout,
   output logic                              ext_wr,
   output logic                              ext_rd,
   output logic [PTR_W-1:0]                  ext_addr,
   output logic [DATA_W-1:0]                 ext_wdata,
   input  logic [DATA_W-1:0]                 ext_rdata,
   output logic [((1<<ADDR_W)-2)*DATA_W-1:0] dir_regs
);
   localparam int NREG = (1 << ADDR_W) - 2;
   localparam logic [ADDR_W-1:0] PTR_ADDR  = ADDR_W'(0);
   localparam logic [ADDR_W-1:0] PORT_ADDR = ADDR_W'(1);

   if (ADDR_W < 2 || ADDR_W > 6) begin : g_bad_addr
      $error("hbus_regs: ADDR_W must lie in 2..6");
   end
   if (PTR_W < 1 || PTR_W > DATA_W) begin : g_bad_ptr
      $error("hbus_regs: PTR_W must lie in 1..DATA_W");
   end

   logic [ADDR_W-1:0] addr_q;
   logic [PTR_W-1:0]  ptr;
   logic [DATA_W-1:0] rd_val;
   logic              at_port;
   logic              at_ptr;

   always_ff @(posedge clk) begin
      if (rst)        addr_q <= '0;
      else if (start) addr_q <= addr;
   end

   assign at_port = (addr_q == PORT_ADDR);
   assign at_ptr  = (addr_q == PTR_ADDR);

   always_ff @(posedge clk) begin
      if (rst) begin
         ptr <= '0;
      end else if (exec) begin
         if (at_ptr && !is_read) ptr <= din[PTR_W-1:0];
         else if (at_port)       ptr <= ptr + 1'b1;
      end
   end

   for (genvar k = 0; k < NREG; k++) begin : g_dreg
      logic [DATA_W-1:0] val;
      always_ff @(posedge clk) begin
         if (rst)
            val <= '0;
         else if (exec && !is_read && addr_q == ADDR_W'(k + 2))
            val <= din;
      end
      assign dir_regs[k*DATA_W +: DATA_W] = val;
   end

   always_comb begin
      rd_val = '0;
      if (at_ptr) begin
         rd_val = DATA_W'(ptr);
      end else if (at_port) begin
         rd_val = ext_rdata;
      end else begin
         for (int k = 0; k < NREG; k++)
            if (addr_q == ADDR_W'(k + 2)) rd_val = dir_regs[k*DATA_W +: DATA_W];
      end
   end

   always_ff @(posedge clk) begin
      if (rst)                 dout <= '0;
      else if (exec && is_read) dout <= rd_val;
   end

   assign ext_rd    = exec && is_read && at_port;
   assign ext_wr    = exec && !is_read && at_port;
   assign ext_addr  = ptr;
   assign ext_wdata = din;

   AST_PTR_STEP: assert property (@(posedge clk) disable iff (rst)
      (exec && at_port) |=> ptr == PTR_W'($past(ptr) + 1'b1));               // R6
   AST_REG_QUIET: assert property (@(posedge clk) disable iff (rst)
      !exec |=> $stable(dir_regs));                                          // R2
endmodule

// File: rtl/hbus_slave.sv
module hbus_slave
   import hbus_pkg::*;
#(
   parameter int ADDR_W      = 3,
   parameter int DATA_W      = 8,
   parameter int PTR_W       = 8,
   parameter int SYNC_STAGES = 2,
   parameter int WAIT_CYC    = 3
) (
   input  logic                              clk,
   input  logic                              rst,
   input  logic [1:0]                        mode_sel,
   input  logic                              cs_a_n,
   input  logic                              cs_b_n,
   input  logic                              rd_n,
   input  logic                              wr_n,
   input  logic [ADDR_W-1:0]                 addr,
   input  logic [DATA_W-1:0]                 din,
   output logic [DATA_W-1:0]                 dout,
   output logic                              dbuf_en_n,
   output logic                              ack_n,
   output logic                              ext_wr,
   output logic                              ext_rd,
   output logic [PTR_W-1:0]                  ext_addr,
   output logic [DATA_W-1:0]                 ext_wdata,
   input  logic [DATA_W-1:0]                 ext_rdata,
   output logic [((1<<ADDR_W)-2)*DATA_W-1:0] dir_regs
);
   logic [3:0] pins_raw;
   logic [3:0] pins_syn;
   proto_t     proto;
   logic       start;
   logic       exec;
   logic       is_read;

   assign pins_raw = {cs_a_n, cs_b_n, rd_n, wr_n};
   assign proto    = (mode_sel == MODE_DSTROBE) ? PROTO_DSTROBE : PROTO_STROBES;

   hbus_sync #(.WIDTH(4), .STAGES(SYNC_STAGES)) u_sync (
      .clk (clk),
      .rst (rst),
      .d   (pins_raw),
      .q   (pins_syn)
   );

   hbus_ctrl #(.WAIT_CYC(WAIT_CYC)) u_ctrl (
      .clk       (clk),
      .rst       (rst),
      .proto     (proto),
      .cs_a_s    (pins_syn[3]),
      .cs_b_s    (pins_syn[2]),
      .rd_s      (pins_syn[1]),
      .wr_s      (pins_syn[0]),
      .start     (start),
      .exec      (exec),
      .is_read   (is_read),
      .dbuf_en_n (dbuf_en_n),
      .ack_n     (ack_n)
   );

   hbus_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .PTR_W(PTR_W)) u_regs (
      .clk       (clk),
      .rst       (rst),
      .start     (start),
      .exec      (exec),
      .is_read   (is_read),
      .addr      (addr),
      .din       (din),
      .dout      (dout),
      .ext_wr    (ext_wr),
      .ext_rd    (ext_rd),
      .ext_addr  (ext_addr),
      .ext_wdata (ext_wdata),
      .ext_rdata (ext_rdata),
      .dir_regs  (dir_regs)
   );

   AST_DBUF_NOT_WRITE: assert property (@(posedge clk) disable iff (rst)
      !dbuf_en_n |-> !ext_wr);                                               // R8
   AST_RESET_QUIET: assert property (@(posedge clk)
      rst |=> (ack_n && dbuf_en_n && !ext_wr && !ext_rd));                   // R1
endmodule

// File: tb/hbus_slave_tb.sv
`timescale 1ns/1ps
module hbus_slave_tb;
   localparam int PW = 4;
   localparam int WC = 4;

   logic        clk = 1'b0;
   logic        rst;
   logic [1:0]  mode_sel;
   logic        cs_a_n, cs_b_n, rd_n, wr_n;
   logic [2:0]  addr;
   logic [7:0]  din;
   logic [7:0]  dout;
   logic        dbuf_en_n, ack_n, ext_wr, ext_rd;
   logic [PW-1:0] ext_addr;
   logic [7:0]  ext_wdata, ext_rdata;
   logic [47:0] dir_regs;

   int n_chk = 0, n_bad = 0;
   int n_wr = 0, n_rd = 0;
   int last_wa = 0, last_wd = 0, last_ra = 0;

   always #5 clk = ~clk;

   function automatic logic [7:0] model_rd(input logic [PW-1:0] a);
      return {a, ~a};
   endfunction

   assign ext_rdata = model_rd(ext_addr);

   hbus_slave #(.ADDR_W(3), .DATA_W(8), .PTR_W(PW), .SYNC_STAGES(2), .WAIT_CYC(WC)) u_dut (
      .clk(clk), .rst(rst), .mode_sel(mode_sel), .cs_a_n(cs_a_n), .cs_b_n(cs_b_n),
      .rd_n(rd_n), .wr_n(wr_n), .addr(addr), .din(din), .dout(dout),
      .dbuf_en_n(dbuf_en_n), .ack_n(ack_n), .ext_wr(ext_wr), .ext_rd(ext_rd),
      .ext_addr(ext_addr), .ext_wdata(ext_wdata), .ext_rdata(ext_rdata), .dir_regs(dir_regs)
   );

   always @(posedge clk) begin
      if (!rst) begin
         if (ext_wr) begin n_wr++; last_wa = int'(ext_addr); last_wd = int'(ext_wdata); end
         if (ext_rd) begin n_rd++; last_ra = int'(ext_addr); end
      end
   end

   task automatic chk(input string req, input string what, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic bus_idle();
      cs_a_n = 1'b1; cs_b_n = 1'b1; rd_n = 1'b1; wr_n = 1'b1;
   endtask

   // one access; lat = clocks to ack low, low = clocks ack low, rel = clocks to release
   task automatic access(input logic moto, input logic wr, input logic [2:0] a,
                         input logic [7:0] d, input int hold,
                         output logic [7:0] rv, output int lat, output int low,
                         output int rel, output logic dbuf_low);
      @(negedge clk);
      mode_sel = moto ? 2'b01 : 2'b00;
      addr = a; din = d; cs_a_n = 1'b0; cs_b_n = 1'b0;
      if (moto) begin wr_n = !wr; rd_n = 1'b0; end
      else if (wr) wr_n = 1'b0;
      else rd_n = 1'b0;
      lat = 0; low = 0; rel = 0; dbuf_low = 1'b0;
      do begin
         @(negedge clk); lat++;
         if (!dbuf_en_n) dbuf_low = 1'b1;
      end while (ack_n && lat < 40);
      if (!moto) begin
         low = 1;
         forever begin
            @(negedge clk);
            if (!dbuf_en_n) dbuf_low = 1'b1;
            if (ack_n || low > 40) break;
            low++;
         end
      end
      for (int i = 0; i < hold; i++) begin
         @(negedge clk);
         if (!dbuf_en_n) dbuf_low = 1'b1;
         if (moto && !ack_n) low++;
      end
      rv = dout;
      bus_idle();
      do begin
         @(negedge clk); rel++;
      end while (!ack_n && rel < 40);
      repeat (4) @(negedge clk);
   endtask

   task automatic wr_reg(input logic moto, input logic [2:0] a, input logic [7:0] d);
      logic [7:0] rv; int l, w, r; logic b;
      access(moto, 1'b1, a, d, 0, rv, l, w, r, b);
   endtask

   task automatic rd_reg(input logic moto, input logic [2:0] a, output logic [7:0] rv);
      int l, w, r; logic b;
      access(moto, 1'b0, a, 8'h00, 0, rv, l, w, r, b);
   endtask

   task automatic t_reset();
      logic [7:0] rv;
      chk("R1", "dout after reset", int'(dout), 0);
      chk("R1", "ack_n after reset", int'(ack_n), 1);
      chk("R1", "dbuf_en_n after reset", int'(dbuf_en_n), 1);
      chk("R1", "dir_regs after reset", int'(dir_regs == 48'h0), 1);
      chk("R1", "no internal strobes", n_wr + n_rd, 0);
      rd_reg(1'b0, 3'd0, rv);
      chk("R1", "pointer after reset", int'(rv), 0);
   endtask

   task automatic t_strobe_timing();
      logic [7:0] rv; int l, w, r; logic b;
      access(1'b0, 1'b1, 3'd0, 8'h05, 0, rv, l, w, r, b);
      chk("R3", "wait latency on write", l, 3);
      chk("R3", "wait length on write", w, WC);
      chk("R8", "buffer enable idle on write", int'(b), 0);
      access(1'b0, 1'b0, 3'd0, 8'h00, 0, rv, l, w, r, b);
      chk("R5", "pointer readback", int'(rv), 5);
      chk("R3", "wait latency on read", l, 3);
      chk("R3", "wait length on read", w, WC);
      chk("R8", "buffer enable on read", int'(b), 1);
      // mode_sel 2'b11 still selects the separate-strobe protocol
      @(negedge clk);
      mode_sel = 2'b11; addr = 3'd0; cs_a_n = 1'b0; cs_b_n = 1'b0; rd_n = 1'b0;
      repeat (3) @(negedge clk);
      chk("R3", "mode 2'b11 wait asserted", int'(ack_n), 0);
      bus_idle();
      repeat (8) @(negedge clk);
   endtask

   task automatic t_port_write();
      logic [7:0] rv;
      int w0 = n_wr;
      wr_reg(1'b0, 3'd1, 8'h77);
      chk("R6", "one write pulse", n_wr - w0, 1);
      chk("R6", "write address = pointer", last_wa, 5);
      chk("R6", "write data", last_wd, 8'h77);
      rd_reg(1'b0, 3'd0, rv);
      chk("R6", "pointer after port write", int'(rv), 6);
   endtask

   task automatic t_dstrobe_read();
      logic [7:0] rv; int l, w, r; logic b;
      int r0 = n_rd;
      access(1'b1, 1'b0, 3'd1, 8'h00, 6, rv, l, w, r, b);
      chk("R6", "port read data", int'(rv), int'(model_rd(4'd6)));
      chk("R6", "one read pulse", n_rd - r0, 1);
      chk("R6", "read address = pointer", last_ra, 6);
      chk("R4", "acknowledge latency", l, 4);
      chk("R4", "acknowledge held with strobe", w, 6);
      chk("R4", "acknowledge release", r, 3);
      chk("R8", "buffer enable on read", int'(b), 1);
      rd_reg(1'b1, 3'd0, rv);
      chk("R6", "pointer after port read", int'(rv), 7);
   endtask

   task automatic t_direct();
      logic [7:0] rv;
      for (int k = 2; k < 8; k++) wr_reg(k[0], 3'(k), 8'(16 * k + k));
      for (int k = 2; k < 8; k++) begin
         chk("R7", $sformatf("dir_regs slice %0d", k),
             int'(dir_regs[(k-2)*8 +: 8]), 16 * k + k);
         rd_reg(!k[0], 3'(k), rv);
         chk("R7", $sformatf("readback reg %0d", k), int'(rv), 16 * k + k);
      end
   endtask

   task automatic t_cs_gate();
      int lowcnt = 0;
      int w0 = n_wr, r0 = n_rd;
      @(negedge clk);
      mode_sel = 2'b00; addr = 3'd3; din = 8'hFF;
      cs_a_n = 1'b0; cs_b_n = 1'b1; wr_n = 1'b0;
      for (int i = 0; i < 10; i++) begin @(negedge clk); if (!ack_n) lowcnt++; end
      bus_idle();
      @(negedge clk);
      addr = 3'd1; cs_a_n = 1'b1; cs_b_n = 1'b0; rd_n = 1'b0;
      for (int i = 0; i < 10; i++) begin @(negedge clk); if (!ack_n) lowcnt++; end
      bus_idle();
      repeat (4) @(negedge clk);
      chk("R2", "no wait with one select high", lowcnt, 0);
      chk("R2", "no internal strobes", (n_wr - w0) + (n_rd - r0), 0);
      chk("R2", "reg 3 unchanged", int'(dir_regs[8 +: 8]), 8'h33);
   endtask

   task automatic t_wrap();
      logic [7:0] rv;
      wr_reg(1'b1, 3'd0, 8'h0F);
      wr_reg(1'b1, 3'd1, 8'h5A);
      chk("R6", "write at max pointer", last_wa, 15);
      chk("R6", "write data at wrap", last_wd, 8'h5A);
      rd_reg(1'b1, 3'd0, rv);
      chk("R6", "pointer wraps to zero", int'(rv), 0);
   endtask

   task automatic t_single();
      logic [7:0] rv; int l, w, r; logic b;
      int r0 = n_rd, w0 = n_wr;
      access(1'b0, 1'b0, 3'd1, 8'h00, 20, rv, l, w, r, b);
      chk("R9", "one read op on long strobe", n_rd - r0, 1);
      access(1'b0, 1'b1, 3'd1, 8'h99, 15, rv, l, w, r, b);
      chk("R9", "one write op on long strobe", n_wr - w0, 1);
      chk("R8", "buffer enable stays high on write", int'(b), 0);
      rd_reg(1'b0, 3'd0, rv);
      chk("R9", "pointer advanced twice", int'(rv), 2);
   endtask

   initial begin
      #2_000_000;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

   initial begin
      rst = 1'b1; mode_sel = 2'b00; addr = '0; din = '0;
      bus_idle();
      repeat (4) @(negedge clk);
      rst = 1'b0;
      repeat (2) @(negedge clk);
      t_reset();
      t_strobe_timing();
      t_port_write();
      t_dstrobe_read();
      t_direct();
      t_cs_gate();
      t_wrap();
      t_single();
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end
endmodule